// File: doc/BRIEF.md
# LED Matrix Single-Cell Scanner

This block lights an 8x8 LED grid from a 64-bit picture word, one LED at a time. Each I/O pin can only source or sink a few milliamps, so the grid is never driven a whole line at once. The block steps through all 64 cells in turn. It drives exactly one row line low and raises the matching column line only when that cell's picture bit is 1.

A free-running prescaler sets how long each cell stays selected. Every time the prescaler rolls over, the scan moves to the next cell. After the last cell the scan returns to cell 0. The hold time is a parameter. A large value slows the scan enough to watch it move cell by cell. The default gives well over 100 complete refreshes per second at a 200 MHz clock (2^14 cycles per cell, about 190 frames per second).

The system places the picture word on `frame` and wires `row_n` and `col` to the grid. The external reset is asserted asynchronously and released through an internal two-stage synchronizer.

Top module: `led_matrix_scanner`

## Requirements
- R1: While `rst_n` is low, and for the first two clock edges after it rises, `row_n` is 8'hFF and `col` is 8'h00. On the third edge after release, cell 0 is shown.
- R2: At most one bit of `row_n` is low in any cycle. Once scanning has begun, exactly one bit is low.
- R3: At most one bit of `col` is high in any cycle.
- R4: Each cell stays selected for exactly 2^PRESCALE_W clock cycles. The scan advances only when the prescaler wraps from all ones to zero.
- R5: The cell position runs 0,1,...,63 and then wraps back to 0.
- R6: For cell position p, the low bit of `row_n` is bit (7 - (p mod 8)).
- R7: For cell position p, `col` equals 8'h80 >> (p / 8) when `frame[p]` is 1, and 8'h00 when `frame[p]` is 0.
- R8: The row and column outputs always come from the same registered cell position. A change on `frame` appears on `col` one clock edge later.
- R9: Pulling `rst_n` low in the middle of a scan idles both buses at once, without waiting for a clock edge. The next release restarts the scan from cell 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame | input | 64 | Picture word, bit p is cell p (row index p mod 8, column index p / 8) |
| row_n | output | 8 | Active-low row select, at most one bit low |
| col | output | 8 | Active-high column drive, at most one bit high |

## Verification
The assertions check three things on every clock edge. Neither bus ever energises more than one line. The cell position holds between prescaler wraps and steps by exactly one on a wrap. Both buses are idle in the cycle after any reset. Some properties only the bench's sweeps can show. These are the exact mapping from cell position to row and column bits, the cycle count each cell is held, the wrap from cell 63 to 0, and the one-edge latency of a picture change. The bench compares the buses against an arithmetic model on every cycle, with a single lit cell walked across all 64 positions and with several dense pictures.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
  localparam int unsigned GRID_DIM = 8;
  localparam int unsigned IDX_W    = $clog2(GRID_DIM);
  localparam int unsigned CELLS    = GRID_DIM * GRID_DIM;
  localparam int unsigned POS_W    = $clog2(CELLS);

  typedef logic [POS_W-1:0]    cell_pos_t;
  typedef logic [IDX_W-1:0]    axis_idx_t;
  typedef logic [GRID_DIM-1:0] lane_t;

  typedef struct packed {
    lane_t row_n;
    lane_t col;
  } drive_t;

  localparam drive_t DRIVE_IDLE = '{row_n: '1, col: '0};
endpackage

// File: rtl/mxs_rst_sync.sv
module mxs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stage_d = 1'b1;
    end else begin : g_chain
      always_comb stage_d = {stage_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/mxs_prescaler.sv
module mxs_prescaler #(
  parameter int unsigned WIDTH = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic wrap
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb cnt_d = cnt_q + WIDTH'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wrap = (cnt_q == '1);
endmodule

// File: rtl/mxs_scan_ctr.sv
module mxs_scan_ctr
  import mxs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  output cell_pos_t pos
);
  cell_pos_t pos_q;
  cell_pos_t pos_d;

  always_comb begin
    pos_d = pos_q;
    if (adv) pos_d = pos_q + cell_pos_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

  // R4: without a prescaler wrap the cell position holds
  p_hold_between_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pos_q));

  // R5: a wrap moves exactly one cell, 63 rolling over to 0
  p_step_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (pos_q == cell_pos_t'($past(pos_q) + 1'b1)));
endmodule

// File: rtl/mxs_cell_drive.sv
module mxs_cell_drive
  import mxs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cell_pos_t        pos,
  input  logic [CELLS-1:0] frame,
  output lane_t            row_n,
  output lane_t            col
);
  axis_idx_t major;
  axis_idx_t minor;
  logic      lit;
  lane_t     row_nx;
  lane_t     col_nx;
  drive_t    drv_d;
  drive_t    drv_q;

  // both axes and the picture bit are taken from one position value
  assign major = pos[POS_W-1:IDX_W];
  assign minor = pos[IDX_W-1:0];
  assign lit   = frame[pos];

  generate
    for (genvar g = 0; g < GRID_DIM; g++) begin : g_lane
      localparam axis_idx_t SEL = axis_idx_t'(GRID_DIM - 1 - g);
      assign row_nx[g] = (minor != SEL);
      assign col_nx[g] = lit & (major == SEL);
    end
  endgenerate

  always_comb drv_d = '{row_n: row_nx, col: col_nx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= DRIVE_IDLE;
    else        drv_q <= drv_d;
  end

  assign row_n = drv_q.row_n;
  assign col   = drv_q.col;

  // R2: never more than one row line pulled low
  p_row_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~drv_q.row_n) <= 1);

  // R3: never more than one column line driven high
  p_col_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_q.col));
endmodule

// File: rtl/led_matrix_scanner.sv
module led_matrix_scanner
  import mxs_pkg::*;
#(
  parameter int unsigned PRESCALE_W = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] frame,
  output logic [7:0]  row_n,
  output logic [7:0]  col
);
  logic      srst_n;
  logic      slot_wrap;
  cell_pos_t scan_pos;

  mxs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  mxs_prescaler #(.WIDTH(PRESCALE_W)) u_pre (
    .clk   (clk),
    .rst_n (srst_n),
    .wrap  (slot_wrap)
  );

  mxs_scan_ctr u_pos (
    .clk   (clk),
    .rst_n (srst_n),
    .adv   (slot_wrap),
    .pos   (scan_pos)
  );

  mxs_cell_drive u_drv (
    .clk   (clk),
    .rst_n (srst_n),
    .pos   (scan_pos),
    .frame (frame),
    .row_n (row_n),
    .col   (col)
  );

  // R1: one edge after any cycle in reset, both buses sit idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !srst_n |=> (row_n == 8'hFF && col == 8'h00));
endmodule

// File: tb/led_matrix_scanner_test.sv
`timescale 1ns/1ps
module led_matrix_scanner_test;
  localparam int PW   = 2;
  localparam int SLOT = 1 << PW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] frame = '0;
  logic [7:0]  row_n;
  logic [7:0]  col;

  int n_vec = 0;
  int n_bad = 0;

  led_matrix_scanner #(.PRESCALE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .frame(frame), .row_n(row_n), .col(col)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] exp_row(int k);
    int p;
    if (k < 0) return 8'hFF;
    p = (k / SLOT) % 64;
    return ~(8'h80 >> (p % 8));
  endfunction

  function automatic logic [7:0] exp_col(int k, logic [63:0] f);
    int p;
    if (k < 0) return 8'h00;
    p = (k / SLOT) % 64;
    return f[p] ? (8'h80 >> (p / 8)) : 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // reset, release with picture f, compare every cycle; optionally swap picture
  task automatic run_pattern(logic [63:0] f, int ncyc, int swap_at, logic [63:0] f2);
    logic [63:0] cur;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 row in reset", row_n, 8'hFF);
      check("R1 col in reset", col, 8'h00);
    end
    cur   = f;
    frame = f;
    rst_n = 1'b1;
    for (int i = 1; i <= ncyc; i++) begin
      @(negedge clk);
      if (i - 3 < 0) begin
        check("R1 row after release", row_n, exp_row(i - 3));
        check("R1 col after release", col, exp_col(i - 3, cur));
      end else begin
        check("R4 R5 R6 row", row_n, exp_row(i - 3));
        check("R7 col", col, exp_col(i - 3, cur));
        check("R2 one row low", 8'($countones(~row_n)), 8'd1);
        check("R3 col onehot0", 8'($countones(col) <= 1), 8'd1);
        if (i - 1 == swap_at) check("R8 col after frame swap", col, exp_col(i - 3, cur));
      end
      if (i == swap_at) begin
        cur   = f2;
        frame = f2;
      end
    end
  endtask

  initial begin
    // dense pictures over two full frames (covers 63 -> 0 wrap)
    run_pattern(64'h0, 2 + SLOT * 128, -1, 64'h0);
    run_pattern('1, 2 + SLOT * 128, -1, 64'h0);
    run_pattern(64'hAA55_AA55_AA55_AA55, 2 + SLOT * 128, -1, 64'h0);
    run_pattern(64'h8000_0000_0000_0001, 2 + SLOT * 128, -1, 64'h0);
    run_pattern(64'h0123_4567_89AB_CDEF, 2 + SLOT * 128, 150, 64'hFEDC_BA98_7654_3210);
    // single lit cell walked over every position
    for (int b = 0; b < 64; b++) run_pattern(64'h1 << b, 2 + SLOT * 64 + SLOT, -1, 64'h0);
    // R9: reset mid-scan idles the buses immediately, without a clock edge
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 37; i++) @(negedge clk);
    #0.5 rst_n = 1'b0;
    #0.5;
    check("R9 row on async reset", row_n, 8'hFF);
    check("R9 col on async reset", col, 8'h00);
    // R9: restart from cell 0 after the mid-scan reset
    run_pattern('1, 2 + SLOT * 8, -1, 64'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule